// File: doc/BRIEF.md
# Serial Transmit Engine with Line Control

This block is the send half of a programmable asynchronous serial port. A host pushes bytes, one per clock, into a 16-entry first-in first-out buffer. A framing state machine takes the oldest byte and sends it on a single serial line. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Bit timing comes from an external enable, `baud_tick`, which pulses once per sample period. Every bit on the line lasts exactly sixteen of these pulses. The word length, parity enable, parity sense and stop-bit count come from static line-control inputs. The engine captures them at the moment it takes a byte from the buffer, so every frame is sent with the settings that held when it started. The buffer level, the empty flag, a sticky overflow flag and a busy flag are provided for status and interrupt logic.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset `tx_line` is 1, `tx_busy` is 0, `fifo_level` is 0, `fifo_empty` is 1 and `fifo_ovf` is 0.
- R2: The buffer holds up to 16 bytes and `fifo_level` reports how many are stored. A write made while 16 bytes are stored is discarded, and the stored bytes are still sent in order.
- R3: A write made while the buffer is full sets `fifo_ovf`. The flag then stays 1 until reset.
- R4: Each frame starts with a single 0 bit. Every bit of the frame is held on the line for exactly 16 `baud_tick` pulses.
- R5: Data bits are sent least significant bit first. The number of data bits is given by `cfg_wlen`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Byte bits above the word length are not sent.
- R6: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd` = 0 the count of ones across the data bits and the parity bit is even. With `cfg_par_odd` = 1 that count is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R7: The frame ends with one stop bit of value 1 when `cfg_stop2` = 0, and with two stop bits of value 1 when `cfg_stop2` = 1.
- R8: If the buffer holds a byte when the last stop bit ends, the next start bit follows with no idle time between the frames. Otherwise the line returns to idle: `tx_line` is 1 and `tx_busy` is 0.
- R9: The line-control inputs are sampled when a byte is taken from the buffer. Changing them during a frame does not alter that frame.
- R10: The line only moves from one bit to the next on a clock cycle in which `baud_tick` is 1. While `baud_tick` stays 0, the current bit is held.
- R11: A byte written into an empty buffer while the engine is idle shows `fifo_level` = 1 in the cycle after the write. In the following cycle it is taken from the buffer: `tx_line` goes to 0, `tx_busy` goes to 1 and `fifo_level` returns to 0.
- R12: `tx_busy` is 1 from the first cycle of the start bit through the end of the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the holding-register port |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | Sample-period enable; 16 pulses make one bit |
| cfg_wlen | input | 2 | Word length code (00=5 … 11=8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| tx_line | output | 1 | Serial output, high when idle |
| tx_busy | output | 1 | A frame is being sent |
| fifo_level | output | 5 | Bytes currently stored (0..16) |
| fifo_empty | output | 1 | Buffer holds no bytes |
| fifo_ovf | output | 1 | Sticky flag: a write was dropped because the buffer was full |

## Verification
A write changes `fifo_level` at the next clock edge. The pop, the fall of the line and the rise of busy all happen at the edge after that. The bench samples on falling clock edges so that each of these values is read half a cycle after the edge that produced it. A monitor finds each start bit on the first falling edge after the line drops. It then reads every following bit 16·P·k + 8·P cycles later, where P is the tick period in clocks; this lands in the middle of bit k whatever the phase of the tick at the pop. With P = 1 every bit is exactly 16 clocks long, so consecutive frames must start exactly 16 clocks times the frame's bit count apart.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int OVERSAMPLE = 16;
    localparam int LEVEL_W    = $clog2(FIFO_DEPTH + 1);
    localparam int PTR_W      = $clog2(FIFO_DEPTH);
    localparam int TICK_W     = $clog2(OVERSAMPLE);
    localparam int IDX_W      = $clog2(DATA_W);

    typedef struct packed {
        logic [1:0] wlen;     // 00=5 .. 11=8 data bits
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } line_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_t;

    // index of the final data bit for a word-length code
    function automatic logic [IDX_W-1:0] last_bit_idx(input logic [1:0] wlen);
        return IDX_W'(4) + IDX_W'(wlen);
    endfunction

    // parity over the bits that are actually sent
    function automatic logic par_calc(input logic [DATA_W-1:0] d,
                                      input logic [1:0]        wlen,
                                      input logic              odd);
        logic [DATA_W-1:0] mask;
        mask = {DATA_W{1'b1}} >> (3 - int'(wlen));
        return (^(d & mask)) ^ odd;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
`timescale 1ns/1ps
module sertx_fifo
    import sertx_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr,
    input  logic [W-1:0]                   wdata,
    input  logic                           rd,
    output logic [W-1:0]                   rdata,
    output logic [$clog2(DEPTH+1)-1:0]     level,
    output logic                           empty,
    output logic                           ovf
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          full;
    logic          wr_ok, rd_ok;

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign rdata = mem[rptr_q];
    assign level = cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (wr_ok) wptr_q <= bump(wptr_q);
            if (rd_ok) rptr_q <= bump(rptr_q);
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (wr && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/sertx_tick_count.sv
`timescale 1ns/1ps
module sertx_tick_count
    import sertx_pkg::*;
#(
    parameter int OVS = OVERSAMPLE
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic bit_done
);
    localparam int CW = $clog2(OVS);

    logic [CW-1:0] cnt_q;

    assign bit_done = tick && (cnt_q == CW'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == CW'(OVS - 1)) ? '0 : cnt_q + CW'(1);
    end
endmodule

// File: rtl/sertx_framer.sv
`timescale 1ns/1ps
module sertx_framer
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  line_cfg_t         cfg_in,
    input  logic              bit_done,
    output logic              pop,
    output logic              tx_line,
    output logic              busy
);
    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              stop_q;
    line_cfg_t         cfg_q;
    logic              par_q;

    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    pop     = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_done) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_done && idx_q == last_bit_idx(cfg_q.wlen))
                    state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (bit_done) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_done && (!cfg_q.stop2 || stop_q)) begin
                    if (!fifo_empty) begin
                        pop     = 1'b1;
                        state_d = ST_START;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            stop_q  <= 1'b0;
            cfg_q   <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pop) begin
                shreg_q <= fifo_rdata;
                cfg_q   <= cfg_in;
                par_q   <= par_calc(fifo_rdata, cfg_in.wlen, cfg_in.par_odd);
                idx_q   <= '0;
                stop_q  <= 1'b0;
            end else begin
                if (state_q == ST_DATA && bit_done) begin
                    shreg_q <= shreg_q >> 1;
                    idx_q   <= idx_q + IDX_W'(1);
                end
                if (state_q == ST_STOP && bit_done) stop_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (state_q)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shreg_q[0];
            ST_PARITY: tx_line = par_q;
            default:   tx_line = 1'b1;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/serial_tx_engine.sv
`timescale 1ns/1ps
module serial_tx_engine
    import sertx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               baud_tick,
    input  logic [1:0]         cfg_wlen,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_stop2,
    output logic               tx_line,
    output logic               tx_busy,
    output logic [LEVEL_W-1:0] fifo_level,
    output logic               fifo_empty,
    output logic               fifo_ovf
);
    line_cfg_t         cfg;
    logic              pop;
    logic              bit_done;
    logic [DATA_W-1:0] head;

    assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, stop2: cfg_stop2};

    sertx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_en),
        .wdata (wr_data),
        .rd    (pop),
        .rdata (head),
        .level (fifo_level),
        .empty (fifo_empty),
        .ovf   (fifo_ovf)
    );

    sertx_tick_count #(.OVS(OVERSAMPLE)) u_ticks (
        .clk      (clk),
        .rst      (rst),
        .clr      (pop),
        .tick     (baud_tick),
        .bit_done (bit_done)
    );

    sertx_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_rdata (head),
        .cfg_in     (cfg),
        .bit_done   (bit_done),
        .pop        (pop),
        .tx_line    (tx_line),
        .busy       (tx_busy)
    );
endmodule

// File: rtl/sertx_checker.sv
`timescale 1ns/1ps
module sertx_checker
    import sertx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               baud_tick,
    input logic               tx_line,
    input logic               tx_busy,
    input logic [LEVEL_W-1:0] fifo_level,
    input logic               fifo_ovf
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LEVEL_W'(FIFO_DEPTH));                                   // R2

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == $past(fifo_level)) ||
        (fifo_level == $past(fifo_level) + LEVEL_W'(1)) ||
        (fifo_level == $past(fifo_level) - LEVEL_W'(1)));                      // R2

    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fifo_level == LEVEL_W'(FIFO_DEPTH)) |=> fifo_ovf);          // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        fifo_ovf |=> fifo_ovf);                                                // R3

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !tx_line);                                          // R4

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_line);                                                 // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && $past(tx_busy) && !$past(baud_tick)) |-> $stable(tx_line)); // R10
endmodule

bind serial_tx_engine sertx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .baud_tick  (baud_tick),
    .tx_line    (tx_line),
    .tx_busy    (tx_busy),
    .fifo_level (fifo_level),
    .fifo_ovf   (fifo_ovf)
);

// File: tb/sim_serial_tx_engine.sv
`timescale 1ns/1ps
module sim_serial_tx_engine;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       tx_line, tx_busy, fifo_empty, fifo_ovf;
    logic [4:0] fifo_level;

    serial_tx_engine u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .tx_line(tx_line),
        .tx_busy(tx_busy), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
        .fifo_ovf(fifo_ovf)
    );

    always #5 clk = ~clk;

    int         n_chk = 0;
    int         n_fail = 0;
    int         tick_p = 1;
    bit         tick_on = 1'b1;
    int         tick_ph = 0;
    bit         mon_on = 1'b1;
    bit         mon_busy = 1'b0;
    int         n_frames = 0;
    int         pushed = 0;
    int         detected = 0;
    logic [7:0] exp_q[$];
    time        st_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_sim;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic bit exp_par(input logic [7:0] d, input int nb, input bit odd);
        bit p = odd;
        for (int i = 0; i < nb; i++) p ^= d[i];
        return p;
    endfunction

    // tick generator: one pulse every tick_p clocks
    initial begin
        forever begin
            @(posedge clk); #1;
            if (!tick_on) begin
                baud_tick = 1'b0;
            end else begin
                tick_ph   = (tick_ph + 1 >= tick_p) ? 0 : tick_ph + 1;
                baud_tick = (tick_ph == 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_sim();
    end

    task automatic decode_frame;
        int         p  = tick_p;
        int         nb = 5 + int'(cfg_wlen);
        bit         pe = cfg_par_en;
        bit         po = cfg_par_odd;
        bit         s2 = cfg_stop2;
        logic [7:0] exp_b, got;
        mon_busy = 1'b1;
        st_q.push_back($time);
        detected++;
        if (exp_q.size() == 0) begin
            exp_b = 8'h00;
            chk(1'b0, "R2", "unexpected frame", 1, 0);
        end else begin
            exp_b = exp_q.pop_front();
        end
        repeat (8 * p) @(negedge clk);
        chk(tx_line == 1'b0, "R4", "start bit mid", tx_line, 0);
        got = 8'h00;
        for (int i = 0; i < nb; i++) begin
            repeat (16 * p) @(negedge clk);
            got[i] = tx_line;
        end
        chk(got == (exp_b & (8'hFF >> (8 - nb))), "R5", "data bits", got,
            exp_b & (8'hFF >> (8 - nb)));
        if (pe) begin
            repeat (16 * p) @(negedge clk);
            chk(tx_line == exp_par(exp_b, nb, po), "R6", "parity bit", tx_line,
                exp_par(exp_b, nb, po));
        end
        repeat (16 * p) @(negedge clk);
        chk(tx_line == 1'b1, "R7", "first stop bit", tx_line, 1);
        if (s2) begin
            repeat (16 * p) @(negedge clk);
            chk(tx_line == 1'b1, "R7", "second stop bit", tx_line, 1);
        end
        n_frames++;
        mon_busy = 1'b0;
    endtask

    // line monitor
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst && mon_on && prev && !tx_line) decode_frame();
            prev = tx_line;
        end
    end

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr_push(input logic [7:0] b);
        exp_q.push_back(b);
        pushed++;
        wr(b);
    endtask

    task automatic drain;
        @(negedge clk);
        while (exp_q.size() != 0 || mon_busy || tx_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset;
        @(posedge clk); #1; rst = 1'b1;
        repeat (3) @(posedge clk); #1; rst = 1'b0;
    endtask

    initial begin
        int f0, fr0;
        time tw;
        void'($urandom(32'd20151));
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1'b1, "R1", "line after reset", tx_line, 1);
        chk(tx_busy == 1'b0, "R1", "busy after reset", tx_busy, 0);
        chk(fifo_level == 0, "R1", "level after reset", fifo_level, 0);
        chk(fifo_empty == 1'b1, "R1", "empty after reset", fifo_empty, 1);
        chk(fifo_ovf == 1'b0, "R1", "ovf after reset", fifo_ovf, 0);

        // R11 and R10: ticks stopped, monitor off
        mon_on = 1'b0; tick_on = 1'b0;
        @(posedge clk); #1;
        wr(8'h5A);
        @(negedge clk);
        chk(fifo_level == 1, "R11", "level after write", fifo_level, 1);
        chk(tx_line == 1'b1, "R11", "line before pop", tx_line, 1);
        @(negedge clk);
        chk(tx_line == 1'b0, "R11", "line after pop", tx_line, 0);
        chk(tx_busy == 1'b1, "R11", "busy after pop", tx_busy, 1);
        chk(fifo_level == 0, "R11", "level after pop", fifo_level, 0);
        repeat (100) @(negedge clk);
        chk(tx_line == 1'b0, "R10", "start held without ticks", tx_line, 0);
        chk(tx_busy == 1'b1, "R12", "busy during held start", tx_busy, 1);
        do_reset();
        tick_on = 1'b1; mon_on = 1'b1;
        repeat (2) @(negedge clk);

        // R8 back-to-back frames, 8 data bits, no parity, 1 stop, tick every clock
        st_q.delete();
        tick_p = 1; cfg_wlen = 2'b11; cfg_par_en = 0; cfg_stop2 = 0;
        @(posedge clk); #1;
        tw = $time;
        wr_push(8'h96); wr_push(8'h27); wr_push(8'hE1);
        drain();
        chk(st_q.size() == 3, "R8", "frame count", st_q.size(), 3);
        if (st_q.size() == 3) begin
            chk(st_q[0] - tw == 24, "R11", "first start time", st_q[0] - tw, 24);
            chk(st_q[1] - st_q[0] == 1600, "R8", "gap 1->2 ns", st_q[1] - st_q[0], 1600);
            chk(st_q[2] - st_q[1] == 1600, "R4", "gap 2->3 ns", st_q[2] - st_q[1], 1600);
        end
        chk(tx_line == 1'b1 && tx_busy == 1'b0, "R8", "idle after drain",
            {tx_line, tx_busy}, 2'b10);

        // R9 settings change mid-frame
        f0 = n_fail; fr0 = n_frames;
        cfg_wlen = 2'b11; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 0;
        @(posedge clk); #1;
        wr_push(8'hA5); wr_push(8'h3C);
        wait (mon_busy);
        repeat (40) @(negedge clk);
        chk(tx_busy == 1'b1, "R12", "busy mid frame", tx_busy, 1);
        cfg_wlen = 2'b00; cfg_par_odd = 1; cfg_stop2 = 1;
        drain();
        chk(n_fail == f0 && n_frames == fr0 + 2, "R9", "frames with changed settings",
            n_frames - fr0, 2);

        // R2, R3 overflow: 18 consecutive writes, first one popped at once
        cfg_wlen = 2'b11; cfg_par_en = 0; cfg_stop2 = 0; cfg_par_odd = 0;
        @(posedge clk); #1;
        for (int i = 0; i < 17; i++) wr_push(8'(8'h40 + i));
        wr(8'hFF);
        @(negedge clk);
        chk(fifo_level == 16, "R2", "level when full", fifo_level, 16);
        chk(fifo_ovf == 1'b1, "R3", "ovf after dropped write", fifo_ovf, 1);
        drain();
        chk(fifo_ovf == 1'b1, "R3", "ovf sticky after drain", fifo_ovf, 1);
        chk(fifo_empty == 1'b1, "R2", "empty after drain", fifo_empty, 1);
        do_reset();
        @(negedge clk);
        chk(fifo_ovf == 1'b0, "R3", "ovf cleared by reset", fifo_ovf, 0);

        // random rounds: settings, tick period, bytes
        for (int r = 0; r < 8; r++) begin
            int nby;
            cfg_wlen    = 2'($urandom % 4);
            cfg_par_en  = 1'($urandom % 2);
            cfg_par_odd = 1'($urandom % 2);
            cfg_stop2   = 1'($urandom % 2);
            tick_p      = 1 + int'($urandom % 3);
            nby         = 1 + int'($urandom % 6);
            @(posedge clk); #1;
            for (int k = 0; k < nby; k++) begin
                repeat (int'($urandom % 20)) begin @(posedge clk); #1; end
                if (pushed - detected < 15) wr_push(8'($urandom));
            end
            drain();
        end
        chk(n_frames == pushed, "R5", "total frames sent", n_frames, pushed);
        finish_sim();
    end
endmodule